// File: doc/BRIEF.md
# Audio Sample FIFO with DMA Request Thresholds

This block buffers 32-bit audio words between a DMA write port and a serial sample bus. The DMA side writes one word per cycle on `dma_wr`. The sample bus takes one word from the head of the queue on each `smp_strobe`, and that word appears on `smp_data`. A control/status register holds the settings: an enable, a flush, a self-clearing soft reset, a parity-generation enable and a channel-count field. The same register reports full, empty and busy, and holds three sticky error flags that are cleared by writing 1.

A second register holds two 6-bit low/high threshold pairs. Each pair drives a request output with hysteresis. `dma_req` asks the DMA engine for more data. `panic_req` raises its priority when the queue is close to running dry. The queue depth is a parameter and must be a power of two, at most 32.

Top module: `aud_sample_fifo`

## Requirements
- R1: After reset, the control register (`reg_addr`=0) reads 0x0000_0200: only the empty flag is set. `smp_data` is 0, and `dma_req` and `panic_req` are both 0.
- R2: While enabled, words written on `dma_wr` leave on `smp_data` in the order they were written, one word per `smp_strobe`. The new word is visible the cycle after the strobe. The full flag (bit 8) sets once DEPTH words are held, and the empty flag (bit 9) sets when no words are held.
- R3: A write while the queue is full is dropped, and the overflow flag (bit 12) sets. The stored words stay as they were.
- R4: A strobe while enabled and empty drives `smp_data` to 0, and sets both the underflow flag (bit 13) and the late flag (bit 14).
- R5: Writing 1 to bit 12, 13 or 14 clears only that flag. Writing 0 leaves the flag as it was. The flags hold until they are cleared.
- R6: Writing 1 to bit 1 (flush) empties the queue and leaves the sticky flags as they were. Bit 1 reads back as 0.
- R7: Writing 1 to bit 2 (soft reset) empties the queue. It also clears the sticky flags, `smp_data`, enable, parity enable and the channel count, and leaves the threshold register unchanged. Bit 2 reads back as 0.
- R8: The threshold register (`reg_addr`=1) holds four 6-bit fields: DMA low in bits [5:0], DMA high in [13:8], panic low in [21:16] and panic high in [29:24]. While enabled, `dma_req` is 1 when the fill level is at or below DMA low, and 0 when the level is at or above DMA high and above DMA low. Between the two levels it holds its previous value. It changes in the same cycle as the level.
- R9: `panic_req` follows the R8 rule using the panic low/high pair, independently of `dma_req`.
- R10: When parity enable (bit 3) is 1, bit 31 of each word leaving the queue is replaced by the XOR of bits 30:0, which gives even parity over the word. When bit 3 is 0, the word leaves unchanged.
- R11: While enable (bit 0) is 0, DMA writes and strobes are ignored. `smp_data` holds its value, no flag sets, and both request outputs are 0.
- R12: Bits [7:4] hold a 4-bit channel count that reads back as written. Busy (bit 10) reads 1 exactly when the block is enabled and the queue is not empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the control/status register, 1 selects the threshold register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| dma_wr | input | 1 | DMA word write strobe |
| dma_wdata | input | 32 | DMA write word |
| smp_strobe | input | 1 | Sample bus pop strobe |
| smp_data | output | 32 | Word most recently popped |
| dma_req | output | 1 | DMA request with hysteresis |
| panic_req | output | 1 | Priority request with hysteresis |

## Verification
- **Register effects and queue flags:** register writes, pushes and their flag updates take effect at the clock edge that samples them, so they are visible one cycle later.
- **Sample output:** `smp_data` is registered. It carries the popped word, or zero on underflow, one cycle after the strobe.
- **Request outputs:** both requests are combinational from the registered fill level, so they move in the same cycle as the level.
- **Bench timing:** the bench drives every input on a falling edge and holds it for exactly one rising edge. It samples outputs and read data at the following falling edge, which is where each of these results is due.

// File: rtl/aud_fifo_pkg.sv
package aud_fifo_pkg;
   localparam int THR_W = 6;
   localparam int WORD_W = 32;

   typedef struct packed {
      logic [THR_W-1:0] lo;
      logic [THR_W-1:0] hi;
   } thr_pair_t;

   // control register bit positions
   localparam int CB_EN    = 0;
   localparam int CB_FLUSH = 1;
   localparam int CB_SRST  = 2;
   localparam int CB_PAR   = 3;
   localparam int CB_CH_LO = 4;
   localparam int CB_FULL  = 8;
   localparam int CB_EMPTY = 9;
   localparam int CB_BUSY  = 10;
   localparam int CB_OVF   = 12;
   localparam int CB_UNF   = 13;
   localparam int CB_LATE  = 14;
endpackage

// File: rtl/aud_fifo_hyst.sv
module aud_fifo_hyst
   import aud_fifo_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [THR_W-1:0] level,
   input  thr_pair_t        thr,
   output logic             req
);
   logic st_q;

   always_comb begin
      if (!en)                req = 1'b0;
      else if (level <= thr.lo) req = 1'b1;
      else if (level >= thr.hi) req = 1'b0;
      else                    req = st_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= 1'b0;
      else        st_q <= req;
   end

   AST_REQ_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (en && level <= thr.lo) |-> req); // R8
   AST_REQ_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && level > thr.lo && level < thr.hi &&
       $stable(level) && $stable(thr)) |-> $stable(req)); // R9
   AST_REQ_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !req); // R11
endmodule

// File: rtl/aud_fifo_store.sv
module aud_fifo_store
   import aud_fifo_pkg::*;
#(
   parameter int DW    = WORD_W,
   parameter int DEPTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             par_en,
   input  logic             clr,
   input  logic             srst,
   input  logic             wr,
   input  logic [DW-1:0]    wdata,
   input  logic             rd,
   output logic             full,
   output logic             empty,
   output logic [THR_W-1:0] level,
   output logic             ovf_evt,
   output logic             unf_evt,
   output logic [DW-1:0]    rdata
);
   localparam int AW    = $clog2(DEPTH);
   localparam int LVL_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("aud_fifo_store: DEPTH must be a power of two, at least 2");
      end
      if (DEPTH >= (1 << THR_W)) begin : g_bad_thr
         $error("aud_fifo_store: DEPTH must fit the threshold width");
      end
      if (DW < 2) begin : g_bad_dw
         $error("aud_fifo_store: DW must leave room for a parity bit");
      end
   endgenerate

   logic [DW-1:0]    mem_q [DEPTH];
   logic [AW-1:0]    wp_q, rp_q;
   logic [LVL_W-1:0] lvl_q;
   logic             push_ok, pop_ok;
   logic [DW-1:0]    head, head_out;

   assign full    = (lvl_q == LVL_W'(DEPTH));
   assign empty   = (lvl_q == '0);
   assign level   = THR_W'(lvl_q);
   assign push_ok = en && wr && !full && !clr;
   assign pop_ok  = en && rd && !empty && !clr;
   assign ovf_evt = en && wr && full && !clr;
   assign unf_evt = en && rd && empty && !clr;

   assign head     = mem_q[rp_q];
   assign head_out = par_en ? {^head[DW-2:0], head[DW-2:0]} : head;

   always_ff @(posedge clk) begin
      if (push_ok) mem_q[wp_q] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         lvl_q <= '0;
      end else if (clr) begin
         wp_q  <= '0;
         rp_q  <= '0;
         lvl_q <= '0;
      end else begin
         if (push_ok) wp_q <= wp_q + 1'b1;
         if (pop_ok)  rp_q <= rp_q + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   lvl_q <= lvl_q + 1'b1;
            2'b01:   lvl_q <= lvl_q - 1'b1;
            default: lvl_q <= lvl_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata <= '0;
      else if (srst)    rdata <= '0;
      else if (pop_ok)  rdata <= head_out;
      else if (unf_evt) rdata <= '0;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_q <= LVL_W'(DEPTH)); // R2
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr && en && !rd && !clr) |=> $stable(lvl_q)); // R3
   AST_UNDER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      unf_evt |=> (rdata == '0)); // R4
   AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty); // R6
endmodule

// File: rtl/aud_fifo_regs.sv
module aud_fifo_regs
   import aud_fifo_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  logic        addr,
   input  logic [31:0] wdata,
   input  logic        full,
   input  logic        empty,
   input  logic        ovf_evt,
   input  logic        unf_evt,
   output logic        en,
   output logic        par_en,
   output logic [3:0]  ch_cnt,
   output logic        flush_p,
   output logic        srst_p,
   output thr_pair_t   thr_dma,
   output thr_pair_t   thr_pan,
   output logic [31:0] rdata
);
   logic       ctrl_wr, thr_wr;
   logic [2:0] stk_q, w1c;   // 0 overflow, 1 underflow, 2 late
   logic       busy;

   assign ctrl_wr = wr && !addr;
   assign thr_wr  = wr && addr;
   assign flush_p = ctrl_wr && wdata[CB_FLUSH];
   assign srst_p  = ctrl_wr && wdata[CB_SRST];
   assign w1c     = ctrl_wr ? wdata[CB_LATE:CB_OVF] : 3'b000;
   assign busy    = en && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= 1'b0;
         par_en <= 1'b0;
         ch_cnt <= '0;
      end else if (srst_p) begin
         en     <= 1'b0;
         par_en <= 1'b0;
         ch_cnt <= '0;
      end else if (ctrl_wr) begin
         en     <= wdata[CB_EN];
         par_en <= wdata[CB_PAR];
         ch_cnt <= wdata[CB_CH_LO+3:CB_CH_LO];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stk_q <= '0;
      else if (srst_p) stk_q <= '0;
      else             stk_q <= (stk_q & ~w1c) | {unf_evt, unf_evt, ovf_evt};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_dma <= '0;
         thr_pan <= '0;
      end else if (thr_wr) begin
         thr_dma.lo <= wdata[5:0];
         thr_dma.hi <= wdata[13:8];
         thr_pan.lo <= wdata[21:16];
         thr_pan.hi <= wdata[29:24];
      end
   end

   always_comb begin
      if (addr) begin
         rdata = {2'b00, thr_pan.hi, 2'b00, thr_pan.lo,
                  2'b00, thr_dma.hi, 2'b00, thr_dma.lo};
      end else begin
         rdata = '0;
         rdata[CB_EN]                = en;
         rdata[CB_PAR]               = par_en;
         rdata[CB_CH_LO+3:CB_CH_LO]  = ch_cnt;
         rdata[CB_FULL]              = full;
         rdata[CB_EMPTY]             = empty;
         rdata[CB_BUSY]              = busy;
         rdata[CB_LATE:CB_OVF]       = stk_q;
      end
   end

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_q[0] && !(ctrl_wr && (wdata[CB_OVF] || wdata[CB_SRST]))) |=> stk_q[0]); // R5
   AST_SRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      srst_p |=> (!en && stk_q == 3'b000)); // R7
endmodule

// File: rtl/aud_sample_fifo.sv
module aud_sample_fifo
   import aud_fifo_pkg::*;
#(
   parameter int DEPTH = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        dma_wr,
   input  logic [31:0] dma_wdata,
   input  logic        smp_strobe,
   output logic [31:0] smp_data,
   output logic        dma_req,
   output logic        panic_req
);
   localparam int N_REQ = 2;

   logic             en, par_en, flush_p, srst_p, clr;
   logic [3:0]       ch_cnt;
   logic             full, empty, ovf_evt, unf_evt;
   logic [THR_W-1:0] level;
   thr_pair_t        thr_dma, thr_pan;
   thr_pair_t        thr_sel [N_REQ];
   logic [N_REQ-1:0] req_vec;

   assign clr = flush_p || srst_p;

   aud_fifo_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .full    (full),
      .empty   (empty),
      .ovf_evt (ovf_evt),
      .unf_evt (unf_evt),
      .en      (en),
      .par_en  (par_en),
      .ch_cnt  (ch_cnt),
      .flush_p (flush_p),
      .srst_p  (srst_p),
      .thr_dma (thr_dma),
      .thr_pan (thr_pan),
      .rdata   (reg_rdata)
   );

   aud_fifo_store #(.DW(WORD_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .par_en  (par_en),
      .clr     (clr),
      .srst    (srst_p),
      .wr      (dma_wr),
      .wdata   (dma_wdata),
      .rd      (smp_strobe),
      .full    (full),
      .empty   (empty),
      .level   (level),
      .ovf_evt (ovf_evt),
      .unf_evt (unf_evt),
      .rdata   (smp_data)
   );

   assign thr_sel[0] = thr_dma;
   assign thr_sel[1] = thr_pan;

   genvar g;
   generate
      for (g = 0; g < N_REQ; g++) begin : g_req
         aud_fifo_hyst u_hyst (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en),
            .level (level),
            .thr   (thr_sel[g]),
            .req   (req_vec[g])
         );
      end
   endgenerate

   assign dma_req   = req_vec[0];
   assign panic_req = req_vec[1];

   AST_CH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr || reg_addr) |=> $stable(ch_cnt)); // R12
endmodule

// File: tb/aud_sample_fifo_tb_top.sv
`timescale 1ns/1ps
module aud_sample_fifo_tb_top;
   localparam int DEPTH = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_addr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        dma_wr = 1'b0;
   logic [31:0] dma_wdata = '0;
   logic        smp_strobe = 1'b0;
   logic [31:0] smp_data;
   logic        dma_req, panic_req;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   aud_sample_fifo #(.DEPTH(DEPTH)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .dma_wr     (dma_wr),
      .dma_wdata  (dma_wdata),
      .smp_strobe (smp_strobe),
      .smp_data   (smp_data),
      .dma_req    (dma_req),
      .panic_req  (panic_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all tasks start and end on a falling edge
   task automatic wreg(input logic a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0; reg_addr = 1'b0;
   endtask

   task automatic rreg(input logic a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
      reg_addr = 1'b0;
   endtask

   task automatic push(input logic [31:0] w);
      dma_wr = 1'b1; dma_wdata = w;
      @(negedge clk);
      dma_wr = 1'b0; dma_wdata = '0;
   endtask

   task automatic pop();
      smp_strobe = 1'b1;
      @(negedge clk);
      smp_strobe = 1'b0;
   endtask

   task automatic chk_ctrl(input string req, input logic [31:0] exp);
      logic [31:0] v;
      rreg(1'b0, v);
      chk(req, v, exp);
   endtask

   task automatic t_reset();
      chk_ctrl("R1 ctrl after reset", 32'h0000_0200);
      chk("R1 smp_data after reset", smp_data, 32'h0);
      chk("R1 dma_req after reset", {31'b0, dma_req}, 32'h0);
      chk("R1 panic_req after reset", {31'b0, panic_req}, 32'h0);
   endtask

   task automatic t_order();
      wreg(1'b0, 32'h4);
      wreg(1'b0, 32'h1);
      push(32'h1111_0001); push(32'h2222_0002); push(32'h3333_0003);
      pop(); chk("R2 order word0", smp_data, 32'h1111_0001);
      pop(); chk("R2 order word1", smp_data, 32'h2222_0002);
      pop(); chk("R2 order word2", smp_data, 32'h3333_0003);
      chk_ctrl("R2 empty after drain", 32'h0000_0201);
      for (int i = 0; i < DEPTH; i++) push(32'hA000_0000 + i);
      chk_ctrl("R2 full after DEPTH words", 32'h0000_0501);
      for (int i = 0; i < DEPTH; i++) begin
         pop();
         chk("R2 full drain order", smp_data, 32'hA000_0000 + i);
      end
   endtask

   task automatic t_overflow();
      wreg(1'b0, 32'h4);
      wreg(1'b0, 32'h1);
      for (int i = 0; i < DEPTH; i++) push(32'hB000_0000 + i);
      push(32'hDEAD_BEEF);
      chk_ctrl("R3 overflow flag on full write", 32'h0000_1501);
      pop(); chk("R3 first word kept", smp_data, 32'hB000_0000);
      for (int i = 1; i < DEPTH; i++) pop();
      chk("R3 last word not overwritten", smp_data, 32'hB000_0000 + DEPTH - 1);
      chk_ctrl("R3 dropped word never stored", 32'h0000_1201);
   endtask

   task automatic t_underflow_w1c();
      wreg(1'b0, 32'h4);
      wreg(1'b0, 32'h1);
      push(32'h5555_AAAA);
      pop(); chk("R4 word before underflow", smp_data, 32'h5555_AAAA);
      pop(); chk("R4 empty pop gives zero", smp_data, 32'h0);
      chk_ctrl("R4 underflow and late set", 32'h0000_6201);
      wreg(1'b0, 32'h0000_2001);
      chk_ctrl("R5 clear underflow only", 32'h0000_4201);
      wreg(1'b0, 32'h0000_0001);
      chk_ctrl("R5 writing zero keeps late", 32'h0000_4201);
      wreg(1'b0, 32'h0000_4001);
      chk_ctrl("R5 clear late", 32'h0000_0201);
   endtask

   task automatic t_flush();
      wreg(1'b0, 32'h4);
      wreg(1'b0, 32'h1);
      for (int i = 0; i < DEPTH; i++) push(32'hC000_0000 + i);
      push(32'h0BAD_0BAD);
      wreg(1'b0, 32'h0000_0003);
      chk_ctrl("R6 flush empties, keeps overflow", 32'h0000_1201);
      pop();
      chk("R6 queue empty after flush", smp_data, 32'h0);
   endtask

   task automatic t_softrst();
      logic [31:0] v;
      wreg(1'b0, 32'h4);
      wreg(1'b1, 32'h0A0B_0C0D);
      wreg(1'b0, 32'h0000_0059);
      push(32'h0000_0101);
      pop();
      pop();
      push(32'h0000_0202); push(32'h0000_0303);
      wreg(1'b0, 32'h0000_0004);
      chk_ctrl("R7 soft reset clears ctrl and flags", 32'h0000_0200);
      chk("R7 soft reset clears smp_data", smp_data, 32'h0);
      rreg(1'b1, v);
      chk("R7 thresholds kept", v, 32'h0A0B_0C0D);
      wreg(1'b0, 32'h1);
      pop();
      chk_ctrl("R7 queue emptied by soft reset", 32'h0000_6201);
   endtask

   task automatic t_hyst();
      wreg(1'b0, 32'h4);
      wreg(1'b1, 32'h0301_0A04);
      wreg(1'b0, 32'h1);
      chk("R8 dma_req at level 0", {31'b0, dma_req}, 32'h1);
      chk("R9 panic_req at level 0", {31'b0, panic_req}, 32'h1);
      push(32'h1); push(32'h2);
      chk("R9 panic holds in band at 2", {31'b0, panic_req}, 32'h1);
      push(32'h3);
      chk("R9 panic off at high 3", {31'b0, panic_req}, 32'h0);
      chk("R8 dma_req holds at 3", {31'b0, dma_req}, 32'h1);
      for (int i = 0; i < 7; i++) push(32'h10 + i);
      chk("R8 dma_req off at high 10", {31'b0, dma_req}, 32'h0);
      for (int i = 0; i < 5; i++) pop();
      chk("R8 dma_req holds off at 5", {31'b0, dma_req}, 32'h0);
      pop();
      chk("R8 dma_req on at low 4", {31'b0, dma_req}, 32'h1);
      pop(); pop();
      chk("R9 panic holds off at 2", {31'b0, panic_req}, 32'h0);
      pop();
      chk("R9 panic on at low 1", {31'b0, panic_req}, 32'h1);
   endtask

   task automatic t_parity();
      wreg(1'b0, 32'h4);
      wreg(1'b0, 32'h9);
      push(32'h0000_0001); pop();
      chk("R10 odd ones gets bit31 set", smp_data, 32'h8000_0001);
      push(32'h8000_0003); pop();
      chk("R10 even ones gets bit31 cleared", smp_data, 32'h0000_0003);
      push(32'h0000_0007); pop();
      chk("R10 three ones gets bit31 set", smp_data, 32'h8000_0007);
      wreg(1'b0, 32'h1);
      push(32'h8000_0003); pop();
      chk("R10 parity off passes bit31", smp_data, 32'h8000_0003);
   endtask

   task automatic t_disabled();
      wreg(1'b0, 32'h4);
      wreg(1'b0, 32'h1);
      push(32'h7777_1234); pop();
      wreg(1'b0, 32'h0);
      chk("R11 dma_req off when disabled", {31'b0, dma_req}, 32'h0);
      chk("R11 panic_req off when disabled", {31'b0, panic_req}, 32'h0);
      pop();
      chk("R11 strobe ignored when disabled", smp_data, 32'h7777_1234);
      push(32'h9999_9999);
      chk_ctrl("R11 no flag while disabled", 32'h0000_0200);
      wreg(1'b0, 32'h1);
      chk_ctrl("R11 disabled write dropped", 32'h0000_0201);
   endtask

   task automatic t_busy_ch();
      wreg(1'b0, 32'h4);
      wreg(1'b0, 32'h0000_00F1);
      chk_ctrl("R12 channel count readback, idle", 32'h0000_02F1);
      push(32'h1);
      chk_ctrl("R12 busy when enabled and holding", 32'h0000_04F1);
      wreg(1'b0, 32'h0000_0030);
      chk_ctrl("R12 not busy when disabled", 32'h0000_0030);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_order();
      t_overflow();
      t_underflow_w1c();
      t_flush();
      t_softrst();
      t_hyst();
      t_parity();
      t_disabled();
      t_busy_ch();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule